// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two 16-bit buses, A and B, and moves words between them in either direction. Each bus is split into two independent byte halves, and each half has a separate storage word for A-to-B traffic and for B-to-A traffic. Every direction of every half has three active-low controls: a gate enable, a latch enable and an output enable. When the gate enable and the latch enable are both low, the half is transparent and the destination follows the source. When either of the two rises, the half keeps the last word it saw. The output enable, together with the gate enable, decides whether the destination port is driven.

The block does not drive a physical bus itself. For each port it presents the incoming bus value, an outgoing data word and a per-bit drive enable, and an external tri-state pad is expected to drive the bus. Storage is clocked. A word is sampled on each rising clock edge while a half is transparent, so "just before the control edge" means the last clock edge at which both controls were still low. An asynchronous active-low reset clears both banks of storage and turns all drivers off.

Top module: `bxcvr_top`

## Requirements
- R1: The 16 bits form two halves: half 0 is bits [7:0] and half 1 is bits [15:8]. Each half uses only its own control bit (index 0 or 1) of each of the six control vectors, and the two halves never affect each other.
- R2: A direction of a half is transparent when its gate enable and its latch enable are both low. While it is transparent and also driven, the destination data output equals the current source input in the same cycle, and its storage takes the source word at every rising clock edge.
- R3: When the latch enable or the gate enable of a direction rises, the storage keeps the source word sampled at the last clock edge at which the half was transparent. From then on, the destination no longer follows the source.
- R4: Whenever a direction is not transparent (gate enable high, latch enable high, or both), its storage does not change. A driven destination then shows the stored word.
- R5: The destination drive enables of a half are all 1 only when that direction's output enable and gate enable are both low and reset is released. Otherwise the drive enables are 0 and the destination data output is 0.
- R6: Capture works while the destination is not driven. A word captured with the output enable high appears on the destination once the output enable goes low with the gate enable low and the latch enable high.
- R7: While the reset input is low, asynchronously, all drive enables are 0, all data outputs are 0 and all stored words are cleared to 0.
- R8: The A-to-B and B-to-A directions keep separate stored words and use separate controls, so activity in one direction leaves the other's stored word and outputs unchanged.
- R9: All eight drive-enable bits of a half always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the storage |
| rstN | input | 1 | Asynchronous reset, active low |
| aIn | input | 16 | Value currently on bus A |
| aOut | output | 16 | Word to drive onto bus A (B-to-A direction) |
| aOe | output | 16 | Per-bit drive enable for bus A pads |
| bIn | input | 16 | Value currently on bus B |
| bOut | output | 16 | Word to drive onto bus B (A-to-B direction) |
| bOe | output | 16 | Per-bit drive enable for bus B pads |
| abEnN | input | 2 | A-to-B gate enable per half, active low |
| abLeN | input | 2 | A-to-B latch enable per half, active low |
| abOeN | input | 2 | A-to-B output enable per half, active low |
| baEnN | input | 2 | B-to-A gate enable per half, active low |
| baLeN | input | 2 | B-to-A latch enable per half, active low |
| baOeN | input | 2 | B-to-A output enable per half, active low |

## Verification
The bench goes after four corner cases. The first is a capture made through a rise of the gate enable rather than the latch enable: a design that listened only to the latch enable would keep following the source. The second is a capture made while the output is off: a design that tied storage to the drive condition would later show a stale word. The third is crossed control bits between halves or directions, which would move or drive the wrong byte. The fourth is a transparent path that is registered instead of direct, which would show last cycle's source. Long stretches of random control and data are then compared cycle by cycle against a behavioural model built from the control rules, and that comparison also catches a driver left on when only one of the two active-low enables is low.

// File: rtl/bxcvr_pkg.sv
package bxcvr_pkg;
  // Per-half, per-direction strobes from control to datapath.
  typedef struct packed {
    logic pass;   // gate and latch enable both low: follow source, sample it
    logic drive;  // output and gate enable both low, reset released
  } strobe_t;
endpackage

// File: rtl/bxcvr_ctrl.sv
module bxcvr_ctrl
  import bxcvr_pkg::*;
#(
  parameter int HALVES = 2
) (
  input  logic                  rstN,
  input  logic [HALVES-1:0]     abEnN,
  input  logic [HALVES-1:0]     abLeN,
  input  logic [HALVES-1:0]     abOeN,
  input  logic [HALVES-1:0]     baEnN,
  input  logic [HALVES-1:0]     baLeN,
  input  logic [HALVES-1:0]     baOeN,
  output strobe_t [HALVES-1:0]  abStb,
  output strobe_t [HALVES-1:0]  baStb
);
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_comb begin
      abStb[h].pass  = ~abEnN[h] & ~abLeN[h];
      abStb[h].drive = rstN & ~abEnN[h] & ~abOeN[h];
      baStb[h].pass  = ~baEnN[h] & ~baLeN[h];
      baStb[h].drive = rstN & ~baEnN[h] & ~baOeN[h];
    end
  end
endmodule

// File: rtl/bxcvr_path.sv
module bxcvr_path
  import bxcvr_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int HALVES = 2,
  localparam int W = HALF_W * HALVES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [W-1:0]         srcIn,
  input  strobe_t [HALVES-1:0] stb,
  output logic [W-1:0]         dstOut,
  output logic [W-1:0]         dstOe
);
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [HALF_W-1:0] stored;
    logic [HALF_W-1:0] srcSlice;
    logic [HALF_W-1:0] shown;

    assign srcSlice = srcIn[h*HALF_W +: HALF_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           stored <= '0;
      else if (stb[h].pass) stored <= srcSlice;
    end

    always_comb begin
      shown = stb[h].pass ? srcSlice : stored;
      dstOut[h*HALF_W +: HALF_W] = stb[h].drive ? shown : '0;
      dstOe[h*HALF_W +: HALF_W]  = {HALF_W{stb[h].drive}};
    end
  end
endmodule

// File: rtl/bxcvr_top.sv
module bxcvr_top
  import bxcvr_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int HALVES = 2,
  localparam int W = HALF_W * HALVES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [W-1:0]      aIn,
  output logic [W-1:0]      aOut,
  output logic [W-1:0]      aOe,
  input  logic [W-1:0]      bIn,
  output logic [W-1:0]      bOut,
  output logic [W-1:0]      bOe,
  input  logic [HALVES-1:0] abEnN,
  input  logic [HALVES-1:0] abLeN,
  input  logic [HALVES-1:0] abOeN,
  input  logic [HALVES-1:0] baEnN,
  input  logic [HALVES-1:0] baLeN,
  input  logic [HALVES-1:0] baOeN
);
  strobe_t [HALVES-1:0] abStb;
  strobe_t [HALVES-1:0] baStb;

  bxcvr_ctrl #(.HALVES(HALVES)) u_ctrl (
    .rstN (rstN),
    .abEnN(abEnN), .abLeN(abLeN), .abOeN(abOeN),
    .baEnN(baEnN), .baLeN(baLeN), .baOeN(baOeN),
    .abStb(abStb), .baStb(baStb)
  );

  // A-to-B bank: sources bus A, drives bus B.
  bxcvr_path #(.HALF_W(HALF_W), .HALVES(HALVES)) u_pathAb (
    .clk(clk), .rstN(rstN), .srcIn(aIn), .stb(abStb),
    .dstOut(bOut), .dstOe(bOe)
  );

  // B-to-A bank: sources bus B, drives bus A.
  bxcvr_path #(.HALF_W(HALF_W), .HALVES(HALVES)) u_pathBa (
    .clk(clk), .rstN(rstN), .srcIn(bIn), .stb(baStb),
    .dstOut(aOut), .dstOe(aOe)
  );
endmodule

// File: rtl/bxcvr_chk.sv
module bxcvr_chk #(
  parameter int HALF_W = 8,
  parameter int HALVES = 2,
  localparam int W = HALF_W * HALVES
) (
  input logic              clk,
  input logic              rstN,
  input logic [W-1:0]      aIn,
  input logic [W-1:0]      aOut,
  input logic [W-1:0]      aOe,
  input logic [W-1:0]      bIn,
  input logic [W-1:0]      bOut,
  input logic [W-1:0]      bOe,
  input logic [HALVES-1:0] abEnN,
  input logic [HALVES-1:0] abLeN,
  input logic [HALVES-1:0] abOeN,
  input logic [HALVES-1:0] baEnN,
  input logic [HALVES-1:0] baLeN,
  input logic [HALVES-1:0] baOeN
);
  // R7: drivers off while reset is held
  p_reset_quiet_r7: assert property (@(posedge clk)
    !rstN |-> (aOe == '0 && bOe == '0 && aOut == '0 && bOut == '0));

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    // R5: disabled direction leaves its destination undriven
    p_hiz_ab_r5: assert property (@(posedge clk) disable iff (!rstN)
      (abOeN[h] || abEnN[h]) |-> (bOe[h*HALF_W +: HALF_W] == '0));
    p_hiz_ba_r5: assert property (@(posedge clk) disable iff (!rstN)
      (baOeN[h] || baEnN[h]) |-> (aOe[h*HALF_W +: HALF_W] == '0));
    p_drive_ab_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!abOeN[h] && !abEnN[h]) |-> (bOe[h*HALF_W +: HALF_W] == '1));
    // R2: transparent and driven destination follows the source
    p_transp_ab_r2: assert property (@(posedge clk) disable iff (!rstN)
      (!abEnN[h] && !abLeN[h] && !abOeN[h]) |->
        (bOut[h*HALF_W +: HALF_W] == aIn[h*HALF_W +: HALF_W]));
    p_transp_ba_r2: assert property (@(posedge clk) disable iff (!rstN)
      (!baEnN[h] && !baLeN[h] && !baOeN[h]) |->
        (aOut[h*HALF_W +: HALF_W] == bIn[h*HALF_W +: HALF_W]));
    // R4: two driven hold cycles in a row show the same word
    p_hold_ab_r4: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !abEnN[h] && abLeN[h] && !abOeN[h] &&
       $past(!abEnN[h] && abLeN[h] && !abOeN[h])) |->
        $stable(bOut[h*HALF_W +: HALF_W]));
    // R9: all drive bits of a half agree
    p_oe_uniform_r9: assert property (@(posedge clk) disable iff (!rstN)
      (aOe[h*HALF_W +: HALF_W] == '0 || aOe[h*HALF_W +: HALF_W] == '1) &&
      (bOe[h*HALF_W +: HALF_W] == '0 || bOe[h*HALF_W +: HALF_W] == '1));
  end
endmodule

bind bxcvr_top bxcvr_chk #(.HALF_W(HALF_W), .HALVES(HALVES)) u_chk (
  .clk(clk), .rstN(rstN), .aIn(aIn), .aOut(aOut), .aOe(aOe),
  .bIn(bIn), .bOut(bOut), .bOe(bOe),
  .abEnN(abEnN), .abLeN(abLeN), .abOeN(abOeN),
  .baEnN(baEnN), .baLeN(baLeN), .baOeN(baOeN)
);

// File: tb/bxcvr_top_bench.sv
module bxcvr_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] aIn = '0, bIn = '0;
  logic [15:0] aOut, aOe, bOut, bOe;
  logic [1:0]  abEnN = '1, abLeN = '1, abOeN = '1;
  logic [1:0]  baEnN = '1, baLeN = '1, baOeN = '1;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  // reference storage: [direction 0=A->B, 1=B->A][half]
  logic [7:0] mem [2][2];

  always #10 clk = ~clk;

  bxcvr_top u_bxcvr_top (
    .clk(clk), .rstN(rstN), .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe),
    .abEnN(abEnN), .abLeN(abLeN), .abOeN(abOeN),
    .baEnN(baEnN), .baLeN(baLeN), .baOeN(baOeN)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string tag);
    for (int d = 0; d < 2; d++) begin
      for (int h = 0; h < 2; h++) begin
        logic en, le, oe, pass, drive;
        logic [7:0] src, val, eOut, eOe, gOut, gOe;
        en  = d == 0 ? abEnN[h] : baEnN[h];
        le  = d == 0 ? abLeN[h] : baLeN[h];
        oe  = d == 0 ? abOeN[h] : baOeN[h];
        src = d == 0 ? aIn[h*8 +: 8] : bIn[h*8 +: 8];
        if (!rstN) mem[d][h] = 8'h00;
        pass  = !en && !le;
        drive = rstN && !en && !oe;
        val   = pass ? src : mem[d][h];
        eOut  = drive ? val : 8'h00;
        eOe   = drive ? 8'hFF : 8'h00;
        gOut  = d == 0 ? bOut[h*8 +: 8] : aOut[h*8 +: 8];
        gOe   = d == 0 ? bOe[h*8 +: 8] : aOe[h*8 +: 8];
        cmp(tag, $sformatf("dir%0d half%0d data", d, h), gOut, eOut);
        cmp(tag, $sformatf("dir%0d half%0d oe", d, h), gOe, eOe);
      end
      if (d == 0 && (aOe & bOe) != 16'h0)
        $display("note: both directions drive the same half at %0t", $time);
    end
  endtask

  task automatic updateModel();
    for (int h = 0; h < 2; h++) begin
      if (!rstN) begin
        mem[0][h] = 8'h00; mem[1][h] = 8'h00;
      end else begin
        if (!abEnN[h] && !abLeN[h]) mem[0][h] = aIn[h*8 +: 8];
        if (!baEnN[h] && !baLeN[h]) mem[1][h] = bIn[h*8 +: 8];
      end
    end
  endtask

  // One cycle: inputs already set after a negedge; check mid-low, then advance.
  task automatic step(input string tag);
    #5 checkAll(tag);
    @(posedge clk); #1 updateModel();
    @(negedge clk);
  endtask

  task automatic setAb(input int h, input bit en, input bit le, input bit oe);
    abEnN[h] = en; abLeN[h] = le; abOeN[h] = oe;
  endtask

  task automatic setBa(input int h, input bit en, input bit le, input bit oe);
    baEnN[h] = en; baLeN[h] = le; baOeN[h] = oe;
  endtask

  initial begin
    for (int d = 0; d < 2; d++) for (int h = 0; h < 2; h++) mem[d][h] = 8'h00;
    @(negedge clk);
    // R7: reset state, even with controls asking for transparency
    setAb(0, 0, 0, 0); setBa(1, 0, 0, 0); aIn = 16'hA55A; bIn = 16'h3CC3;
    step("R7 reset");
    step("R7 reset");
    rstN = 1'b1;
    setAb(0, 1, 1, 1); setBa(1, 1, 1, 1);
    step("R7 after reset");

    // R2: transparent A->B half 0 follows source each cycle
    setAb(0, 0, 0, 0); aIn = 16'h0011; step("R2 transparent");
    aIn = 16'h0022; step("R2 transparent");
    // R3: latch enable rises; keeps 22 though source changes
    setAb(0, 0, 1, 0); aIn = 16'h0099; step("R3 capture by latch enable");
    aIn = 16'h0077; step("R4 hold");
    // R3 + R6: capture via gate enable rise, output off meanwhile
    setAb(0, 0, 0, 1); aIn = 16'h0044; step("R6 transparent undriven");
    setAb(0, 1, 0, 1); aIn = 16'h00EE; step("R3 capture by gate enable");
    setAb(0, 1, 0, 0); step("R5 gate enable high undriven");
    setAb(0, 0, 1, 0); step("R6 captured word displayed");
    // R5: output enable high alone disables
    setAb(0, 0, 1, 1); step("R5 output enable high");

    // R1: half 1 independent from half 0
    setAb(0, 0, 1, 0); setAb(1, 0, 0, 0); aIn = 16'hC3D4; step("R1 half1 transparent");
    setAb(1, 0, 1, 0); aIn = 16'h0000; step("R1 halves separate");

    // R8: B->A direction independent
    setBa(0, 0, 0, 0); setBa(1, 0, 0, 0); bIn = 16'h5A6B; step("R8 both directions");
    setBa(0, 0, 1, 0); setBa(1, 0, 1, 0); bIn = 16'hFFFF; step("R8 B to A hold");
    setAb(0, 0, 0, 0); aIn = 16'h1234; step("R8 A to B activity");
    setAb(0, 0, 1, 0); step("R8 stored words kept");

    // R7: reset mid-run clears stored words
    rstN = 1'b0; step("R7 reset mid-run");
    rstN = 1'b1; setAb(0, 0, 1, 0); setBa(1, 0, 1, 0); step("R7 cleared words");

    // Random phase: R2 R3 R4 R5 R9 compared on every cycle
    for (int i = 0; i < 3000; i++) begin
      {abEnN, abLeN, abOeN} = 6'($urandom);
      {baEnN, baLeN, baOeN} = 6'($urandom);
      aIn = 16'($urandom); bIn = 16'($urandom);
      if (($urandom % 200) == 0) rstN = 1'b0; else rstN = 1'b1;
      step("R4 R5 R9 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule